// File: doc/BRIEF.md
# Inverter Gate Protection Supervisor

This block sits between the six PWM switch commands of a three-phase bridge (one high-side and one low-side command per phase) and the six gate-enable outputs that reach the gate drivers. All commands are active high: a high command asks for that switch to conduct. External comparators supply digital fault flags. These are a low-side short-circuit detect, trip and release flags for the low-side supply, trip and release flags for each phase's high-side supply, and trip and release flags for over-temperature. The supervisor registers every input through a two-flop synchronizer before using it.

Faults are handled according to their kind. A short circuit, a low-side supply drop or an over-temperature condition removes all three low-side gates and pulls the active-low fault output down. A short circuit holds the output low for a fixed minimum width. The two supply and temperature faults hold it low for at least that width and for as long as their latched state lasts. A high-side supply drop on one phase removes only that phase's high-side gate and leaves the fault output high. Supply and temperature faults are latched between their trip flag and their release flag, so hysteresis does not depend on analog behaviour.

A switch that has been blanked does not resume when the fault clears. Each switch resumes on its own, only after its command goes low and then high again. The same rule applies after reset. The minimum fault width is a cycle count derived from the clock-frequency parameter `CLK_KHZ` and the width parameter `MIN_FAULT_US`. With the defaults this is 2000 cycles.

Top module: `gate_guard`

## Requirements
- R1: Once armed, a gate output follows its command, where command bit i and gate bit i belong to phase i (0 to 2). A high command turns the gate on, and a low command turns it off.
- R2: A high short-circuit detect forces all three low-side gates low within 3 clock cycles and keeps them low while the detect stays high. High-side gates are unaffected.
- R3: A rising edge of the short-circuit detect drives `fault_n` low for at least HOLD = CLK_KHZ*MIN_FAULT_US/1000 cycles and releases it within HOLD+10 cycles, however long the detect stays high. A new rising edge while `fault_n` is low restarts the width.
- R4: A gate blanked by any fault stays low after the fault ends, even with its command still high. It turns on again only after its own command shows a low-then-high transition, and each of the six gates re-arms independently.
- R5: A low-side supply trip flag latches a low-side under-voltage state. This state keeps all low-side gates low and holds `fault_n` low for at least HOLD cycles and until the low-side release flag is seen.
- R6: A high-side supply trip flag on phase i latches a state that forces only high-side gate i low and leaves `fault_n` high. After the phase's release flag is seen, the gate recovers on the next rising edge of its command.
- R7: An over-temperature trip flag latches a state that keeps all low-side gates low and holds `fault_n` low for at least HOLD cycles and until the over-temperature release flag is seen.
- R8: While `rst_n` is low, all gates are low and `fault_n` is high. After reset, a gate whose command was already high stays low until that command has gone low and then high.
- R9: When a trip flag and its release flag are high together, the trip wins and the fault state stays latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 3 | High-side switch commands, bit i = phase i |
| cmd_lo | input | 3 | Low-side switch commands, bit i = phase i |
| sc_det | input | 1 | Low-side short-circuit detect |
| lsuv_trip | input | 1 | Low-side supply below trip level |
| lsuv_clr | input | 1 | Low-side supply above release level |
| hsuv_trip | input | 3 | High-side supply below trip level, per phase |
| hsuv_clr | input | 3 | High-side supply above release level, per phase |
| ot_trip | input | 1 | Temperature above trip level |
| ot_clr | input | 1 | Temperature below release level |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Active-low fault report |

## Verification
The hardest state to reach from the ports is a gate that is disarmed but has no fault present. Its command is high, nothing blocks it, and it is still low. The stimulus keeps the commands high across each fault and checks the gate after the fault ends. It then toggles one phase at a time to show that only the toggled gate comes back. Restarting the fault width also needs a precise setup: the stimulus places a second short-circuit edge halfway through the first pulse and samples on both sides of where each pulse would end. Trip-over-release priority is exposed by holding both flags high and checking that the low-side gates stay low.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;
  function automatic int hold_cycles(input int clk_khz, input int width_us);
    return (clk_khz * width_us) / 1000;
  endfunction
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gg_latch.sv
module gg_latch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] trip,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= trip | (st & ~clr);
  end

  // R9: trip wins over release
  p_trip_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip != '0) |=> ((st & $past(trip)) == $past(trip)));
endmodule

// File: rtl/gg_pulse.sv
module gg_pulse #(
  parameter int HOLD = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic level,
  output logic fault_n
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      fault_n <= 1'b1;
    end else begin
      if (load)           cnt <= HOLD_V;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      fault_n <= !(load || level || (cnt != '0));
    end
  end

  // R3: counter never exceeds its reload
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HOLD_V);
  // R3: a reload always reports the fault
  p_load_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !fault_n);
endmodule

// File: rtl/gg_phase.sv
module gg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic blank,
  output logic gate
);
  logic prev, armed, rise;
  assign rise = cmd & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b1;
      armed <= 1'b0;
      gate  <= 1'b0;
    end else begin
      prev  <= cmd;
      armed <= blank ? 1'b0 : (rise | armed);
      gate  <= ~blank & cmd & (armed | rise);
    end
  end

  // R4: a gate only turns on from an armed state or a fresh edge
  p_rearm_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rise) |=> !gate);
  // R1: an armed, unblanked gate follows a high command
  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd && !blank) |=> gate);
endmodule

// File: rtl/gate_guard.sv
module gate_guard #(
  parameter int CLK_KHZ      = 100000,
  parameter int MIN_FAULT_US = 20,
  parameter int PHASES       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] cmd_hi,
  input  logic [PHASES-1:0] cmd_lo,
  input  logic              sc_det,
  input  logic              lsuv_trip,
  input  logic              lsuv_clr,
  input  logic [PHASES-1:0] hsuv_trip,
  input  logic [PHASES-1:0] hsuv_clr,
  input  logic              ot_trip,
  input  logic              ot_clr,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              fault_n
);
  import gate_guard_pkg::*;
  localparam int HOLD = hold_cycles(CLK_KHZ, MIN_FAULT_US);
  localparam int NCMD = 2 * PHASES;
  localparam int NFLT = 5 + 2 * PHASES;

  logic [NCMD-1:0] cmd_s;
  logic [NFLT-1:0] flt_s;
  logic sc_s, sc_prev, lsuv_trip_s, lsuv_clr_s, ot_trip_s, ot_clr_s;
  logic [PHASES-1:0] hsuv_trip_s, hsuv_clr_s, hsuv_st;
  logic lsuv_st, ot_st, load, lo_blank;

  gg_sync #(.W(NCMD), .RST_VAL({NCMD{1'b1}})) u_cmd_sync (
    .clk(clk), .rst_n(rst_n), .d({cmd_hi, cmd_lo}), .q(cmd_s));
  gg_sync #(.W(NFLT), .RST_VAL('0)) u_flt_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sc_det, lsuv_trip, lsuv_clr, ot_trip, ot_clr, hsuv_trip, hsuv_clr}),
    .q(flt_s));

  assign {sc_s, lsuv_trip_s, lsuv_clr_s, ot_trip_s, ot_clr_s,
          hsuv_trip_s, hsuv_clr_s} = flt_s;

  gg_latch #(.W(1)) u_lsuv (.clk(clk), .rst_n(rst_n),
    .trip(lsuv_trip_s), .clr(lsuv_clr_s), .st(lsuv_st));
  gg_latch #(.W(1)) u_ot (.clk(clk), .rst_n(rst_n),
    .trip(ot_trip_s), .clr(ot_clr_s), .st(ot_st));
  gg_latch #(.W(PHASES)) u_hsuv (.clk(clk), .rst_n(rst_n),
    .trip(hsuv_trip_s), .clr(hsuv_clr_s), .st(hsuv_st));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_prev <= 1'b0;
    else        sc_prev <= sc_s;
  end

  assign load = (sc_s & ~sc_prev) | (lsuv_trip_s & ~lsuv_st) | (ot_trip_s & ~ot_st);
  assign lo_blank = sc_s | lsuv_st | ot_st;

  gg_pulse #(.HOLD(HOLD)) u_pulse (.clk(clk), .rst_n(rst_n),
    .load(load), .level(lsuv_st | ot_st), .fault_n(fault_n));

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    gg_phase u_hi (.clk(clk), .rst_n(rst_n), .cmd(cmd_s[PHASES + i]),
      .blank(hsuv_st[i]), .gate(gate_hi[i]));
    gg_phase u_lo (.clk(clk), .rst_n(rst_n), .cmd(cmd_s[i]),
      .blank(lo_blank), .gate(gate_lo[i]));

    // R6: high-side supply loss removes only that phase's high gate
    p_hs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hsuv_st[i] |=> !gate_hi[i]);
  end

  // R2: short circuit clears every low-side gate
  p_sc_lo_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_s |=> (gate_lo == '0));
  // R3: short-circuit edge is reported
  p_sc_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_s) |=> !fault_n);
  // R5: latched low-side supply fault is reported
  p_lsuv_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lsuv_st |=> !fault_n);
  // R7: latched over-temperature is reported
  p_ot_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ot_st |=> !fault_n);
  // R8: reset keeps the bridge off and the report quiet
  p_rst_safe_r8: assert property (@(posedge clk)
    !rst_n |=> (gate_hi == '0 && gate_lo == '0 && fault_n));
endmodule

// File: tb/test_gate_guard.sv
module test_gate_guard;
  localparam int HOLD = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_hi = 3'b111, cmd_lo = 3'b111;
  logic sc_det = 0, lsuv_trip = 0, lsuv_clr = 0, ot_trip = 0, ot_clr = 0;
  logic [2:0] hsuv_trip = 0, hsuv_clr = 0;
  logic [2:0] gate_hi, gate_lo;
  logic fault_n;

  always #5 clk = ~clk;

  gate_guard i_gate_guard (.clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .sc_det(sc_det), .lsuv_trip(lsuv_trip), .lsuv_clr(lsuv_clr),
    .hsuv_trip(hsuv_trip), .hsuv_clr(hsuv_clr), .ot_trip(ot_trip), .ot_clr(ot_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n));

  typedef struct {
    string      tag;
    logic [2:0] hi;
    logic [2:0] lo;
    logic       f;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [2:0] hi,
                            input logic [2:0] lo, input logic f);
    exp_t e;
    e.tag = tag; e.hi = hi; e.lo = lo; e.f = f;
    q.push_back(e);
  endtask

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (gate_hi !== e.hi || gate_lo !== e.lo || fault_n !== e.f) begin
          n_fail++;
          $display("FAIL %s: hi=%b lo=%b fault_n=%b expected hi=%b lo=%b fault_n=%b",
                   e.tag, gate_hi, gate_lo, fault_n, e.hi, e.lo, e.f);
        end
      end
    end
  end

  task automatic rearm_lo(input logic [2:0] v);
    cmd_lo = 3'b000; step(4);
    cmd_lo = v;      step(6);
  endtask

  task automatic pulse(ref logic sig, input int n);
    sig = 1'b1; step(n); sig = 1'b0;
  endtask

  initial begin
    // R8: reset with commands already high
    step(5);
    expect_out("R8 in reset", 3'b000, 3'b000, 1'b1);
    rst_n = 1'b1; step(8);
    expect_out("R8 no edge after reset", 3'b000, 3'b000, 1'b1);

    // R1: arm with a low-then-high transition
    cmd_hi = 3'b000; cmd_lo = 3'b000; step(5);
    cmd_hi = 3'b111; cmd_lo = 3'b101; step(6);
    expect_out("R1 follow", 3'b111, 3'b101, 1'b1);
    cmd_hi = 3'b010; step(6);
    expect_out("R1 follow low", 3'b010, 3'b101, 1'b1);
    cmd_hi = 3'b111; cmd_lo = 3'b111; step(6);
    expect_out("R1 follow high", 3'b111, 3'b111, 1'b1);

    // R2/R3: short circuit pulse
    pulse(sc_det, 3); step(5);
    expect_out("R2 lo blanked hi kept", 3'b111, 3'b000, 1'b0);
    step(HOLD - 30);
    expect_out("R3 still low near width", 3'b111, 3'b000, 1'b0);
    step(40);
    expect_out("R3 released / R4 stays off", 3'b111, 3'b000, 1'b1);

    // R4: independent re-arm
    cmd_lo[0] = 1'b0; step(4); cmd_lo[0] = 1'b1; step(6);
    expect_out("R4 phase0 only", 3'b111, 3'b001, 1'b1);
    cmd_lo[2] = 1'b0; step(4); cmd_lo[2] = 1'b1; step(6);
    expect_out("R4 phase2 only", 3'b111, 3'b101, 1'b1);
    rearm_lo(3'b111);
    expect_out("R4 all rearmed", 3'b111, 3'b111, 1'b1);

    // R3: long detect, width fixed
    sc_det = 1'b1; step(HOLD + 60);
    expect_out("R3 width independent of detect", 3'b111, 3'b000, 1'b1);
    sc_det = 1'b0; step(6);
    rearm_lo(3'b111);

    // R3: restart on a new edge
    pulse(sc_det, 3); step(HOLD / 2);
    pulse(sc_det, 3); step(HOLD / 2 + 40);
    expect_out("R3 restarted width", 3'b111, 3'b000, 1'b0);
    step(HOLD / 2);
    expect_out("R3 restarted width ends", 3'b111, 3'b000, 1'b1);
    rearm_lo(3'b111);

    // R5: low-side supply latch
    pulse(lsuv_trip, 3); step(5);
    expect_out("R5 lo blanked", 3'b111, 3'b000, 1'b0);
    step(HOLD + 50);
    expect_out("R5 held until release", 3'b111, 3'b000, 1'b0);
    pulse(lsuv_clr, 3); step(6);
    expect_out("R5 released", 3'b111, 3'b000, 1'b1);
    rearm_lo(3'b111);

    // R9: trip and release together
    lsuv_trip = 1'b1; lsuv_clr = 1'b1; step(HOLD + 50);
    cmd_lo = 3'b000; step(4); cmd_lo = 3'b111; step(6);
    expect_out("R9 trip wins", 3'b111, 3'b000, 1'b0);
    lsuv_trip = 1'b0; step(10); lsuv_clr = 1'b0; step(6);
    expect_out("R9 released after trip drops", 3'b111, 3'b000, 1'b1);
    rearm_lo(3'b111);

    // R7: over-temperature
    pulse(ot_trip, 3); step(HOLD + 50);
    expect_out("R7 held until release", 3'b111, 3'b000, 1'b0);
    pulse(ot_clr, 3); step(6);
    expect_out("R7 released", 3'b111, 3'b000, 1'b1);
    rearm_lo(3'b111);
    pulse(ot_trip, 3); step(10);
    pulse(ot_clr, 3); step(100);
    expect_out("R7 minimum width", 3'b111, 3'b000, 1'b0);
    step(HOLD);
    expect_out("R7 minimum width ends", 3'b111, 3'b000, 1'b1);
    rearm_lo(3'b111);

    // R6: high-side supply on phase 1
    hsuv_trip[1] = 1'b1; step(3); hsuv_trip[1] = 1'b0; step(5);
    expect_out("R6 only hi1 off, silent", 3'b101, 3'b111, 1'b1);
    hsuv_clr[1] = 1'b1; step(3); hsuv_clr[1] = 1'b0; step(6);
    expect_out("R6 waits for edge", 3'b101, 3'b111, 1'b1);
    cmd_hi[1] = 1'b0; step(4); cmd_hi[1] = 1'b1; step(6);
    expect_out("R6 recovered", 3'b111, 3'b111, 1'b1);

    step(3);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule